// File: doc/BRIEF.md
# Multichannel TDM Channel Selector

This block runs beside a serial word receiver or transmitter whose frame carries up to 128 word slots. It follows the slot position within each frame, using a frame sync pulse and a word-complete strobe from the neighbouring shifter. For every slot it reports whether that slot's word is taken. The receiver uses the capture strobe to store the word. The transmitter uses the same enable to drive its data pin, and releases the pin to high impedance when the enable is low. Slots that are not selected are still counted, so the slot timing stays aligned to the frame.

Selection comes from a 128-bit mask held as eight 16-bit partitions. Partition p covers channels 16p to 16p+15. Software writes one partition at a time through a write port. Written values go into a shadow copy. That copy moves into the live mask only when a frame sync is accepted, so the selection never changes in the middle of a frame. When multichannel mode is off, every slot in the frame is passed. An optional event pulses each time a block of 16 channels has been completed.

The slot tracker is a three-state machine:
- `ST_IDLE`: after reset, no frame yet.
- `ST_RUN`: counting slots.
- `ST_DONE`: the frame length has been reached; the machine waits for the next sync.

Its transitions are:
- `T_START`: `ST_IDLE`→`ST_RUN` on a sync.
- `T_RESYNC`: `ST_RUN`→`ST_RUN` on a sync in the middle of a frame.
- `T_END`: `ST_RUN`→`ST_DONE` on the word at the last slot.
- `T_REARM`: `ST_DONE`→`ST_RUN` on a sync.

A sync has priority over a word strobe arriving in the same cycle.

Top module: `tdm_slot_gate`

## Requirements
- R1: After reset, `in_frame`, `slot_en`, `rx_strobe` and `block_irq` are 0, `slot_idx` is 0, and all mask bits are 0.
- R2: When `frame_sync` is high at a clock edge, then from the next cycle `in_frame`=1 and `slot_idx`=0. The frame length is latched from `frame_len` at that edge: a value n gives n+1 slots. Later changes to `frame_len` do not affect the current frame.
- R3: Each `word_done` pulse while `in_frame`=1 moves `slot_idx` forward by one. After a `word_done` at slot n (the latched length), `in_frame` falls. While `in_frame`=0, `word_done` changes neither `slot_idx` nor any output.
- R4: A write with `mask_we`=1 stores `mask_data` into partition `mask_part` (0 to 7). Bit i of that partition selects channel 16·`mask_part`+i.
- R5: With `mc_mode`=1, `slot_en` equals `in_frame` AND the live mask bit for `slot_idx`. Slots that are not selected still advance `slot_idx`.
- R6: With `mc_mode`=0, `slot_en` equals `in_frame` for every slot, whatever the mask holds.
- R7: `rx_strobe` is high in exactly the cycles where `word_done` and `slot_en` are both high.
- R8: Mask writes become live only at the next accepted `frame_sync`. A write in the same cycle as a sync goes live at the sync after that one.
- R9: With `irq_en`=1 and `mc_mode`=1, `block_irq` pulses for one cycle. It does so in the cycle after a `word_done` (in frame, without a sync) at a slot whose low four bits are 15. `block_irq` stays 0 otherwise, including when `mc_mode`=0.
- R10: A `frame_sync` during a frame restarts the frame at slot 0. If `word_done` arrives in the same cycle as the sync, it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Accepted frame sync pulse |
| word_done | input | 1 | One-cycle strobe at the end of each word slot |
| frame_len | input | 7 | Number of slots minus one, latched at sync |
| mc_mode | input | 1 | 1 = pass only selected slots |
| irq_en | input | 1 | Enables the 16-channel block event |
| mask_we | input | 1 | Mask partition write strobe |
| mask_part | input | 3 | Partition index, 0 to 7 |
| mask_data | input | 16 | Partition value, bit i = channel 16·part+i |
| in_frame | output | 1 | Slot counter is running |
| slot_idx | output | 7 | Current slot number |
| slot_en | output | 1 | Current slot is taken (transmit drive enable) |
| rx_strobe | output | 1 | Capture this word |
| block_irq | output | 1 | 16-channel block completed |

## Verification
The bench builds the block with its default sizes of 128 slots and 16-bit partitions. With these sizes the walk reaches the top slot 127 and the last partition. The block event can be seen at two successive partition boundaries within one frame. Table entries probe single mask bits in the first, middle and last partitions, with multichannel mode both on and off. Directed tests then cover:
- the end of a short frame;
- mask writes made mid-frame and in the same cycle as a sync;
- a restart in the middle of a frame that collides with a word strobe.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } slot_state_e;

endpackage

// File: rtl/tdm_mask_bank.sv
module tdm_mask_bank #(
    parameter int NUM_SLOTS = 128,
    parameter int PART_W    = 16,
    localparam int NUM_PARTS  = NUM_SLOTS / PART_W,
    localparam int PART_SEL_W = (NUM_PARTS > 1) ? $clog2(NUM_PARTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PART_SEL_W-1:0] wr_part,
    input  logic [PART_W-1:0]     wr_data,
    input  logic                  load,
    output logic [NUM_SLOTS-1:0]  live_mask
);

    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
        logic [PART_W-1:0] shadow_q;
        logic [PART_W-1:0] live_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q <= '0;
            end else if (wr_en && (wr_part == PART_SEL_W'(p))) begin
                shadow_q <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q <= '0;
            end else if (load) begin
                live_q <= shadow_q;
            end
        end

        assign live_mask[p*PART_W +: PART_W] = live_q;
    end

endmodule

// File: rtl/tdm_slot_fsm.sv
module tdm_slot_fsm
    import tdm_sel_pkg::*;
#(
    parameter int NUM_SLOTS = 128,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              word_done,
    input  logic [SLOT_W-1:0] frame_len,
    output logic              in_frame,
    output logic              slot_adv,
    output logic [SLOT_W-1:0] slot_q,
    output logic [SLOT_W-1:0] len_q
);

    slot_state_e state_q, state_d;
    logic        at_last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: sync always wins over a word strobe
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (frame_sync) state_d = ST_RUN;               // T_START
            ST_RUN: begin
                if (frame_sync)                  state_d = ST_RUN;   // T_RESYNC
                else if (word_done && at_last)   state_d = ST_DONE;  // T_END
            end
            ST_DONE: if (frame_sync) state_d = ST_RUN;               // T_REARM
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_frame = (state_q == ST_RUN);
        at_last  = (slot_q == len_q);
        slot_adv = in_frame && word_done && !frame_sync;
    end

    // slot counter and latched length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            len_q  <= '0;
        end else if (frame_sync) begin
            slot_q <= '0;
            len_q  <= frame_len;
        end else if (slot_adv && !at_last) begin
            slot_q <= slot_q + 1'b1;
        end
    end

endmodule

// File: rtl/tdm_block_event.sv
module tdm_block_event #(
    parameter int PART_W = 16,
    localparam int LOW_W = $clog2(PART_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_adv,
    input  logic             mc_mode,
    input  logic             irq_en,
    input  logic [LOW_W-1:0] slot_low,
    output logic             irq_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= slot_adv && mc_mode && irq_en && (&slot_low);
        end
    end

endmodule

// File: rtl/tdm_slot_gate.sv
module tdm_slot_gate #(
    parameter int NUM_SLOTS = 128,
    parameter int PART_W    = 16,
    localparam int NUM_PARTS  = NUM_SLOTS / PART_W,
    localparam int PART_SEL_W = (NUM_PARTS > 1) ? $clog2(NUM_PARTS) : 1,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int LOW_W      = $clog2(PART_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_sync,
    input  logic                  word_done,
    input  logic [SLOT_W-1:0]     frame_len,
    input  logic                  mc_mode,
    input  logic                  irq_en,
    input  logic                  mask_we,
    input  logic [PART_SEL_W-1:0] mask_part,
    input  logic [PART_W-1:0]     mask_data,
    output logic                  in_frame,
    output logic [SLOT_W-1:0]     slot_idx,
    output logic                  slot_en,
    output logic                  rx_strobe,
    output logic                  block_irq
);

    logic [NUM_SLOTS-1:0] live_mask;
    logic [SLOT_W-1:0]    len_q;
    logic                 slot_adv;
    logic                 slot_sel;

    tdm_mask_bank #(.NUM_SLOTS(NUM_SLOTS), .PART_W(PART_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mask_we),
        .wr_part   (mask_part),
        .wr_data   (mask_data),
        .load      (frame_sync),
        .live_mask (live_mask)
    );

    tdm_slot_fsm #(.NUM_SLOTS(NUM_SLOTS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .word_done  (word_done),
        .frame_len  (frame_len),
        .in_frame   (in_frame),
        .slot_adv   (slot_adv),
        .slot_q     (slot_idx),
        .len_q      (len_q)
    );

    tdm_block_event #(.PART_W(PART_W)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_adv (slot_adv),
        .mc_mode  (mc_mode),
        .irq_en   (irq_en),
        .slot_low (slot_idx[LOW_W-1:0]),
        .irq_q    (block_irq)
    );

    always_comb begin
        slot_sel  = mc_mode ? live_mask[slot_idx] : 1'b1;
        slot_en   = in_frame && slot_sel;
        rx_strobe = word_done && slot_en;
    end

endmodule

// File: rtl/tdm_slot_gate_chk.sv
module tdm_slot_gate_chk #(
    parameter int NUM_SLOTS = 128,
    parameter int PART_W    = 16,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int LOW_W  = $clog2(PART_W)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_sync,
    input logic                 word_done,
    input logic                 mc_mode,
    input logic                 in_frame,
    input logic [SLOT_W-1:0]    slot_idx,
    input logic [SLOT_W-1:0]    len_q,
    input logic                 slot_en,
    input logic                 rx_strobe,
    input logic                 block_irq,
    input logic [NUM_SLOTS-1:0] live_mask
);

    assert_sync_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (in_frame && slot_idx == '0));

    assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && word_done && !frame_sync && slot_idx != len_q)
        |=> (slot_idx == $past(slot_idx) + 1'b1));

    assert_frame_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && word_done && !frame_sync && slot_idx == len_q) |=> !in_frame);

    assert_en_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en |-> in_frame);

    assert_pass_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_mode && in_frame) |-> slot_en);

    assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> (word_done && slot_en));

    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(live_mask));

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        block_irq |-> ($past(word_done) && $past(in_frame) && $past(mc_mode)
                       && (&$past(slot_idx[LOW_W-1:0]))));

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        block_irq |=> !block_irq);

endmodule

bind tdm_slot_gate tdm_slot_gate_chk #(.NUM_SLOTS(NUM_SLOTS), .PART_W(PART_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .word_done  (word_done),
    .mc_mode    (mc_mode),
    .in_frame   (in_frame),
    .slot_idx   (slot_idx),
    .len_q      (len_q),
    .slot_en    (slot_en),
    .rx_strobe  (rx_strobe),
    .block_irq  (block_irq),
    .live_mask  (live_mask)
);

// File: tb/tdm_slot_gate_bench.sv
module tdm_slot_gate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic        word_done = 1'b0;
    logic [6:0]  frame_len = '0;
    logic        mc_mode = 1'b0;
    logic        irq_en = 1'b0;
    logic        mask_we = 1'b0;
    logic [2:0]  mask_part = '0;
    logic [15:0] mask_data = '0;
    logic        in_frame;
    logic [6:0]  slot_idx;
    logic        slot_en;
    logic        rx_strobe;
    logic        block_irq;

    int n_checks = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tdm_slot_gate u_tdm_slot_gate (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .word_done(word_done),
        .frame_len(frame_len), .mc_mode(mc_mode), .irq_en(irq_en),
        .mask_we(mask_we), .mask_part(mask_part), .mask_data(mask_data),
        .in_frame(in_frame), .slot_idx(slot_idx), .slot_en(slot_en),
        .rx_strobe(rx_strobe), .block_irq(block_irq)
    );

    // {part[2:0], data[15:0], offset[3:0], mc}
    localparam logic [23:0] TBL [8] = '{
        {3'd0, 16'h0001, 4'd0,  1'b1},
        {3'd0, 16'h0001, 4'd1,  1'b1},
        {3'd7, 16'h8000, 4'd15, 1'b1},
        {3'd7, 16'h7FFF, 4'd15, 1'b1},
        {3'd3, 16'h0020, 4'd5,  1'b1},
        {3'd3, 16'h0000, 4'd5,  1'b0},
        {3'd5, 16'hA5A5, 4'd2,  1'b1},
        {3'd5, 16'hA5A5, 4'd3,  1'b1}
    };

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_mask(input logic [2:0] p, input logic [15:0] d);
        @(negedge clk);
        mask_we = 1'b1; mask_part = p; mask_data = d;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic sync(input logic [6:0] len);
        @(negedge clk);
        frame_len = len; frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
    endtask

    task automatic word(output logic strobe_seen, output logic irq_after);
        @(negedge clk);
        word_done = 1'b1;
        #1 strobe_seen = rx_strobe;
        @(negedge clk);
        word_done = 1'b0;
        irq_after = block_irq;
    endtask

    task automatic advance(input int n);
        logic s, q;
        for (int k = 0; k < n; k++) word(s, q);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        logic s, q;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(int'(in_frame), 0, "R1 in_frame");
        check(int'(slot_idx), 0, "R1 slot_idx");
        check(int'(slot_en), 0, "R1 slot_en");
        check(int'(block_irq), 0, "R1 block_irq");
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(rx_strobe), 0, "R1 rx_strobe");

        // table walk: R4 partition mapping, R5 selection, R6 mode off
        for (int i = 0; i < 8; i++) begin
            logic [2:0]  p;
            logic [15:0] d;
            logic [3:0]  off;
            logic        mc;
            int          exp_en;
            {p, d, off, mc} = TBL[i];
            exp_en = mc ? int'(d[off]) : 1;
            mc_mode = mc;
            wr_mask(p, d);
            sync(7'd127);
            advance(16 * int'(p) + int'(off));
            check(int'(slot_idx), 16 * int'(p) + int'(off), "R5 slot count through gated slots");
            check(int'(slot_en), exp_en, mc ? "R4 R5 mask select" : "R6 pass all");
        end

        // R7 capture strobe
        mc_mode = 1'b1;
        wr_mask(3'd0, 16'h0001);
        sync(7'd127);
        word(s, q);
        check(int'(s), 1, "R7 strobe enabled slot");
        word(s, q);
        check(int'(s), 0, "R7 strobe disabled slot");

        // R2 length latch, R3 frame end and ignored strobes
        sync(7'd2);
        frame_len = 7'd100;
        advance(2);
        check(int'(in_frame), 1, "R2 still in frame");
        check(int'(slot_idx), 2, "R3 slot at last");
        word(s, q);
        check(int'(in_frame), 0, "R2 R3 frame ended at latched length");
        word(s, q);
        check(int'(s), 0, "R3 strobe outside frame");
        check(int'(slot_idx), 2, "R3 slot frozen outside frame");
        check(int'(slot_en), 0, "R3 no enable outside frame");

        // R8 deferred mask update
        sync(7'd127);                  // live part0 = 0x0001
        wr_mask(3'd0, 16'h0002);
        check(int'(slot_en), 1, "R8 slot0 old mask mid frame");
        advance(1);
        check(int'(slot_en), 0, "R8 slot1 old mask mid frame");
        sync(7'd127);
        check(int'(slot_en), 0, "R8 slot0 new mask");
        advance(1);
        check(int'(slot_en), 1, "R8 slot1 new mask");
        @(negedge clk);                // write coincident with sync
        mask_we = 1'b1; mask_part = 3'd0; mask_data = 16'h0004;
        frame_sync = 1'b1; frame_len = 7'd127;
        @(negedge clk);
        mask_we = 1'b0; frame_sync = 1'b0;
        advance(1);
        check(int'(slot_en), 1, "R8 coincident write not yet live");
        sync(7'd127);
        advance(2);
        check(int'(slot_en), 1, "R8 coincident write live next frame");

        // R9 block event
        irq_en = 1'b1;
        mc_mode = 1'b1;
        sync(7'd127);
        for (int k = 0; k < 32; k++) begin
            word(s, q);
            check(int'(q), ((k % 16) == 15) ? 1 : 0, "R9 block irq");
        end
        @(negedge clk);
        check(int'(block_irq), 0, "R9 pulse is single cycle");
        mc_mode = 1'b0;
        sync(7'd127);
        advance(15);
        word(s, q);
        check(int'(q), 0, "R9 no irq with mode off");
        irq_en = 1'b0;

        // R10 restart with colliding word strobe
        sync(7'd127);
        advance(5);
        @(negedge clk);
        frame_sync = 1'b1; word_done = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0; word_done = 1'b0;
        check(int'(slot_idx), 0, "R10 restart slot");
        check(int'(in_frame), 1, "R10 restart in frame");

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule